// File: doc/BRIEF.md
# Serial Configuration Port with Live Status Return

This block is the four-wire serial slave in front of a radio's configuration register file. The controller pulls chip select low, and the first byte it sends is a header. That header names a register, says whether the access reads or writes, and says whether one data byte or a run of data bytes follows. The slave turns each data byte into a request on a register-file port. In a run, it steps the register address after every byte. Headers that point into a reserved upper address range with no run requested are command strobes. They produce a one-cycle pulse that carries the address, and they involve no register access.

While every header, strobe and write-data byte shifts in, the slave shifts a status byte out on its serial output. That byte carries an active-low ready flag for the crystal oscillator and the 3-bit radio state code. During read-data bytes the register contents take the place of the status byte. Before the first clock edge of a byte, the output shows the live ready flag. The controller can therefore poll the serial output after lowering chip select and begin clocking once the output reads low.

All serial pins are brought into the system clock domain through synchronizers, and edges are detected there. The serial clock must therefore run well below the system clock (at least 12 system clocks per serial bit). The register-file port uses valid/ready handshakes. A read or write request stays asserted, with address and data stable, until ready is seen high. A read must be accepted before the falling serial edge that opens the data byte, or stale data is shifted out. A write must be accepted before the next byte completes, or the newer request replaces it.

Top module: `spi_status_slave`

## Requirements
- R1: The serial output enable is high only while the synchronized chip select is low; it is low out of reset and while chip select is high.
- R2: While chip select is low and a status byte is waiting for its first rising serial edge, the serial output follows the inverted crystal-ready input live (1 when not running).
- R3: A status byte is, MSB first: bit 7 = inverted crystal-ready, bits 6:4 = radio state code, bits 3:0 = 0. Its fields are frozen at the byte's first rising serial edge.
- R4: Serial input is sampled on rising serial edges, MSB first. The serial output changes only after falling edges (the serial clock idles low), so the first bit is on the output before the first rising edge.
- R5: Header bit 7 = 1 selects read and 0 selects write, bit 6 = 1 selects a run of data bytes, and bits 5:0 give the register address.
- R6: A single write makes exactly one write request, carrying the header address and the data byte. The status byte is returned during both bytes, and the byte after the data byte is decoded as a new header.
- R7: A single read issues a read request for the header address when the header completes. The returned register value is shifted out MSB first during the following data byte.
- R8: In a run, the address increments after every data byte and wraps from 63 to 0. Reads fetch the next address ahead so that consecutive bytes return consecutive registers.
- R9: A header with bit 6 clear and an address of at least 0x30 is a strobe. It gives a one-cycle strobe pulse with the address as its code, makes no register request, and the next byte is a header.
- R10: Raising chip select discards a partly shifted byte, clears the bit count and ends any run. No request results from the discarded byte, and the next transfer starts with a header.
- R11: Read and write requests stay asserted, with stable address and data, until ready is sampled high.
- R12: After reset no request or strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (high-impedance when low) |
| xtal_ready | input | 1 | Crystal oscillator running |
| radio_state | input | 3 | Current radio state code |
| rd_valid | output | 1 | Register read request |
| rd_ready | input | 1 | Register file accepts the read |
| rd_addr | output | 6 | Read address |
| rd_data | input | 8 | Read data, valid while rd_valid and rd_ready are high |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register file accepts the write |
| wr_addr | output | 6 | Write address |
| wr_data | output | 8 | Write data |
| strobe_valid | output | 1 | One-cycle command strobe pulse |
| strobe_code | output | 6 | Address of the strobe |

## Verification
Some properties are checked on every cycle. The assertions cover the single-cycle width and reserved range of the strobe pulse and the holding of pending requests under back-pressure. They also cover clearing of the bit count when chip select rises, the serial output staying still except at falling edges or during the live-status window, and the output reading high while the crystal is not running. Other behaviour needs whole serial transactions, so only the bench's scenarios can show it. That covers the byte contents shifted out, correct header decoding, the address stepping and wrapping in runs, the freezing of status fields mid-byte, the return to header decoding after a strobe or an aborted byte, and writes landing in the right registers.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int STATE_W = 3;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int PAD_W   = BYTE_W - 1 - STATE_W;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } hdr_t;

  typedef enum logic [0:0] {
    PH_HDR,
    PH_DATA
  } phase_e;

  function automatic logic [BYTE_W-1:0] status_byte(input logic ready,
                                                    input logic [STATE_W-1:0] st);
    status_byte = {~ready, st, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/sstat_sync.sv
module sstat_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise[b] = q[b] & ~prev[b];
    assign fall[b] = ~q[b] & prev[b];
  end
endmodule

// File: rtl/sstat_rx.sv
module sstat_rx
  import sstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              si,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_end,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shreg_nxt;

  assign byte_end  = cs_act && sclk_rise && (bit_cnt == LAST_BIT);
  assign shreg_nxt = {shreg[BYTE_W-2:0], si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sclk_rise) begin
        shreg   <= shreg_nxt;
        bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
        if (byte_end) begin
          byte_done <= 1'b1;
          rx_byte   <= shreg_nxt;
        end
      end
    end
  end

  // R10: chip select high leaves no partial byte behind
  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0) && !byte_done);
endmodule

// File: rtl/sstat_ctrl.sv
module sstat_ctrl
  import sstat_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STROBE_BASE = ADDR_W'(6'h30)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              strobe_valid,
  output logic [ADDR_W-1:0] strobe_code,
  output logic              data_sel,
  output logic [BYTE_W-1:0] data_byte
);
  phase_e            phase;
  logic              is_read;
  logic              is_burst;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BYTE_W-1:0] rd_buf;
  hdr_t              hdr;
  logic              hit_strobe;

  assign hdr        = hdr_t'(rx_byte);
  assign hit_strobe = !hdr.burst && (hdr.addr >= STROBE_BASE);
  assign nxt_addr   = cur_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_HDR;
      is_read      <= 1'b0;
      is_burst     <= 1'b0;
      cur_addr     <= '0;
      rd_buf       <= '0;
      rd_valid     <= 1'b0;
      rd_addr      <= '0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      strobe_valid <= 1'b0;
      strobe_code  <= '0;
    end else begin
      strobe_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        rd_buf   <= rd_data;
      end
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (!cs_act) begin
        phase <= PH_HDR;
      end else if (byte_done) begin
        if (phase == PH_HDR) begin
          if (hit_strobe) begin
            strobe_valid <= 1'b1;
            strobe_code  <= hdr.addr;
          end else begin
            phase    <= PH_DATA;
            is_read  <= hdr.rd;
            is_burst <= hdr.burst;
            cur_addr <= hdr.addr;
            if (hdr.rd) begin
              rd_valid <= 1'b1;
              rd_addr  <= hdr.addr;
            end
          end
        end else begin
          if (!is_read) begin
            wr_valid <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= rx_byte;
          end
          if (is_burst) begin
            cur_addr <= nxt_addr;
            if (is_read) begin
              rd_valid <= 1'b1;
              rd_addr  <= nxt_addr;
            end
          end else begin
            phase <= PH_HDR;
          end
        end
      end
    end
  end

  assign data_sel  = (phase == PH_DATA) && is_read;
  assign data_byte = rd_buf;

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid |=> !strobe_valid);

  p_strobe_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid |-> (strobe_code >= STROBE_BASE));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R6: a single data byte returns decoding to the header phase
  p_single_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && phase == PH_DATA && !is_burst) |=> (phase == PH_HDR));
endmodule

// File: rtl/sstat_tx.sv
module sstat_tx
  import sstat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_act,
  input  logic               sclk_fall,
  input  logic               byte_end,
  input  logic               first_slot,
  input  logic               data_sel,
  input  logic [BYTE_W-1:0]  data_byte,
  input  logic               xtal_ready,
  input  logic [STATE_W-1:0] radio_state,
  output logic               so_o,
  output logic               so_oe
);
  logic [BYTE_W-1:0] tx;
  logic              tx_stat;
  logic              pend;
  logic [BYTE_W-1:0] status_now;
  logic              live_win;

  assign status_now = status_byte(xtal_ready, radio_state);
  assign live_win   = tx_stat && !pend && first_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= status_byte(1'b0, '0);
      tx_stat <= 1'b1;
      pend    <= 1'b0;
    end else if (!cs_act) begin
      tx      <= status_now;
      tx_stat <= 1'b1;
      pend    <= 1'b0;
    end else if (byte_end) begin
      pend <= 1'b1;
    end else if (sclk_fall) begin
      if (pend) begin
        tx      <= data_sel ? data_byte : status_now;
        tx_stat <= !data_sel;
        pend    <= 1'b0;
      end else begin
        tx <= {tx[BYTE_W-2:0], 1'b0};
      end
    end else if (live_win) begin
      tx <= status_now;
    end
  end

  assign so_o  = tx[BYTE_W-1];
  assign so_oe = cs_act;

  p_notready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && live_win && !sclk_fall && !xtal_ready) |=> so_o);

  p_so_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall && !live_win) |=> $stable(so_o));
endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
  import sstat_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STROBE_BASE = ADDR_W'(6'h30)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csn,
  input  logic               sclk,
  input  logic               si,
  output logic               so_o,
  output logic               so_oe,
  input  logic               xtal_ready,
  input  logic [STATE_W-1:0] radio_state,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               strobe_valid,
  output logic [ADDR_W-1:0]  strobe_code
);
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b100;

  logic [PIN_N-1:0]  pin_q, pin_rise, pin_fall;
  logic              cs_act;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_end, byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              data_sel;
  logic [BYTE_W-1:0] data_byte;

  sstat_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({csn, sclk, si}),
    .q    (pin_q),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cs_act = ~pin_q[2];

  sstat_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sclk_rise(pin_rise[1]),
    .si       (pin_q[0]),
    .bit_cnt  (bit_cnt),
    .byte_end (byte_end),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  sstat_ctrl #(
    .STROBE_BASE(STROBE_BASE)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .strobe_valid(strobe_valid),
    .strobe_code (strobe_code),
    .data_sel    (data_sel),
    .data_byte   (data_byte)
  );

  sstat_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sclk_fall  (pin_fall[1]),
    .byte_end   (byte_end),
    .first_slot (bit_cnt == '0),
    .data_sel   (data_sel),
    .data_byte  (data_byte),
    .xtal_ready (xtal_ready),
    .radio_state(radio_state),
    .so_o       (so_o),
    .so_oe      (so_oe)
  );
endmodule

// File: tb/spi_status_slave_test.sv
module spi_status_slave_test;
  localparam int HALF = 6;
  localparam int NVEC = 6;
  // {state, header, data, expected read value}
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd1, 8'h05, 8'hA5, 8'h00},
    {3'd2, 8'h2A, 8'h3C, 8'h00},
    {3'd3, 8'h85, 8'h00, 8'hA5},
    {3'd4, 8'hAA, 8'h00, 8'h3C},
    {3'd5, 8'h00, 8'hFF, 8'h00},
    {3'd0, 8'h80, 8'h00, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic csn = 1, sclk = 0, si = 0;
  logic so_o, so_oe;
  logic xtal_ready = 1;
  logic [2:0] radio_state = 0;
  logic rd_valid, rd_ready = 1, wr_valid, wr_ready = 1;
  logic [5:0] rd_addr, wr_addr, strobe_code;
  logic [7:0] rd_data, wr_data;
  logic strobe_valid;
  logic [7:0] mem [64];
  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0, stb_cnt = 0;
  logic [5:0] last_stb = 0;

  always #5 clk = ~clk;

  spi_status_slave uut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .si(si),
    .so_o(so_o), .so_oe(so_oe), .xtal_ready(xtal_ready), .radio_state(radio_state),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobe_valid(strobe_valid), .strobe_code(strobe_code)
  );

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else begin
      if (wr_valid && wr_ready) begin
        mem[wr_addr] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (rd_valid && rd_ready) rd_cnt <= rd_cnt + 1;
      if (strobe_valid) begin
        stb_cnt  <= stb_cnt + 1;
        last_stb <= strobe_code;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk) csn = 0;
    wait_clk(6);
  endtask

  task automatic cs_high();
    wait_clk(2);
    csn = 1;
    wait_clk(6);
  endtask

  // shifts nbits of b MSB first; radio_state changes to nst at the end of bit chg
  task automatic xfer(input logic [7:0] b, input int nbits, input int chg,
                      input logic [2:0] nst, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = b[i];
      wait_clk(HALF);
      r[i] = so_o;
      sclk = 1;
      wait_clk(HALF);
      if (i == chg) radio_state = nst;
      sclk = 0;
    end
  endtask

  function automatic logic [7:0] stat(input logic rdy, input logic [2:0] s);
    return {~rdy, s, 4'b0000};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [2:0] st;
    logic [7:0] hdr, dat, rexp;
    int wc, rc, sc;

    wait_clk(4);
    check("R12 rd_valid after reset", rd_valid, 0);
    check("R12 wr_valid after reset", wr_valid, 0);
    check("R12 strobe after reset", strobe_valid, 0);
    check("R1 so_oe after reset", so_oe, 0);
    rst_n = 1;
    wait_clk(4);
    check("R1 so_oe with csn high", so_oe, 0);

    // table of single accesses
    for (int v = 0; v < NVEC; v++) begin
      {st, hdr, dat, rexp} = VEC[v];
      radio_state = st;
      cs_low();
      check("R1 so_oe with csn low", so_oe, 1);
      xfer(hdr, 8, -1, 3'd0, r);
      check("R3 R4 status during header", r, stat(1'b1, st));
      xfer(dat, 8, -1, 3'd0, r);
      if (hdr[7]) check("R5 R7 read data", r, rexp);
      else        check("R5 R6 status during write data", r, stat(1'b1, st));
      cs_high();
    end
    check("R6 one write per single write", wr_cnt, 3);
    check("R7 one read per single read", rd_cnt, 3);

    // live ready flag before clocking
    xtal_ready = 0;
    radio_state = 3'd6;
    cs_low();
    check("R2 so high while crystal stopped", so_o, 1);
    xtal_ready = 1;
    wait_clk(3);
    check("R2 so low once crystal runs", so_o, 0);

    // strobe with status frozen after the first rising edge
    wc = wr_cnt; rc = rd_cnt; sc = stb_cnt;
    xfer(8'h36, 8, 7, 3'd2, r);
    check("R3 status frozen at first edge", r, stat(1'b1, 3'd6));
    wait_clk(2);
    check("R9 one strobe pulse", stb_cnt, sc + 1);
    check("R9 strobe code", last_stb, 6'h36);
    check("R9 no register access on strobe", wr_cnt + rd_cnt, wc + rc);
    xfer(8'h07, 8, -1, 3'd0, r);
    check("R9 next byte is header with status", r, stat(1'b1, 3'd2));
    xfer(8'h11, 8, -1, 3'd0, r);
    cs_high();
    check("R9 write after strobe landed", mem[7], 8'h11);

    // burst write across the wrap, then burst read
    radio_state = 3'd1;
    cs_low();
    xfer(8'h7E, 8, -1, 3'd0, r);
    xfer(8'h01, 8, -1, 3'd0, r);
    check("R8 status during burst write", r, stat(1'b1, 3'd1));
    xfer(8'h02, 8, -1, 3'd0, r);
    xfer(8'h03, 8, -1, 3'd0, r);
    cs_high();
    check("R8 burst byte 0 at 0x3E", mem[62], 8'h01);
    check("R8 burst byte 1 at 0x3F", mem[63], 8'h02);
    check("R8 burst byte 2 wraps to 0", mem[0], 8'h03);
    cs_low();
    xfer(8'hFE, 8, -1, 3'd0, r);
    xfer(8'h00, 8, -1, 3'd0, r);
    check("R8 burst read 0x3E", r, 8'h01);
    xfer(8'h00, 8, -1, 3'd0, r);
    check("R8 burst read 0x3F", r, 8'h02);
    xfer(8'h00, 8, -1, 3'd0, r);
    check("R8 burst read wrapped 0", r, 8'h03);
    cs_high();

    // abort a partial data byte
    wc = wr_cnt;
    cs_low();
    xfer(8'h09, 8, -1, 3'd0, r);
    xfer(8'hFF, 4, -1, 3'd0, r);
    cs_high();
    wait_clk(4);
    check("R10 aborted byte makes no write", wr_cnt, wc);
    cs_low();
    xfer(8'h89, 8, -1, 3'd0, r);
    check("R10 next transfer starts with header", r, stat(1'b1, 3'd1));
    xfer(8'h00, 8, -1, 3'd0, r);
    check("R10 register untouched", r, 8'h00);
    cs_high();

    // write back-pressure
    wr_ready = 0;
    cs_low();
    xfer(8'h10, 8, -1, 3'd0, r);
    xfer(8'h5A, 8, -1, 3'd0, r);
    cs_high();
    check("R11 write held while not ready", wr_valid, 1);
    check("R11 write address held", wr_addr, 6'h10);
    check("R11 write data held", wr_data, 8'h5A);
    wr_ready = 1;
    wait_clk(3);
    check("R11 write released", wr_valid, 0);
    check("R11 held write landed", mem[16], 8'h5A);
    check("R1 so_oe released", so_oe, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule